// File: doc/BRIEF.md
# Zero-Residue Input Sample Modifier

This stage sits in front of a filter protected by two full-width branches and a modulo-m checking branch. A coefficient upset in such a filter goes unseen whenever the sample that multiplies it has residue zero modulo m. The stage prevents this by nudging every sample that is a multiple of m by one unit. All three branches then receive the same nudged sample. Samples with nonzero residue pass through untouched.

The nudge follows a two-bit mode input, which is chosen to suit the filter's response. Mode 00 inverts the least significant bit. Mode 01 adds +1 and −1 in turn, which puts the injected energy near half the sample rate and suits a low-pass filter. Modes 10 and 11 always add +1, which puts the energy at DC and suits a high-pass or bandpass filter.

The stage is one register deep and reports which output samples were altered. The sample width and the modulus are parameters. The defaults are an 8-bit sample and m = 3, and m = 7 is supported as well.

Top module: `zres_precond`

## Requirements
- R1: After the first clock edge following reset, every output sample, read as a signed two's-complement value, has a nonzero remainder modulo MOD.
- R2: An input sample whose signed value is not a multiple of MOD appears unchanged on `dout` one cycle later, with `dmod` low.
- R3: With mode 00, a sample that is a multiple of MOD is output with bit 0 inverted and all other bits unchanged.
- R4: With mode 01, successive modified samples receive +1, −1, +1, … in turn, and the first modified sample after reset receives +1.
- R5: The alternation state advances only on a modified sample taken in mode 01. Unmodified samples and samples modified in other modes leave it where it was.
- R6: With mode 10 or 11, a sample that is a multiple of MOD is output as the sample plus one.
- R7: If the chosen step of +1 would exceed the largest signed value, −1 is applied instead. If a step of −1 would go below the smallest signed value, +1 is applied instead. In mode 01 the alternation still advances.
- R8: `dout` and `dmod` are registered one cycle after `din`. `dmod` is high exactly when the sample taken one cycle earlier was a multiple of MOD.
- R9: While `rst_n` is low, `dout` is zero and `dmod` is low, and the alternation state is cleared so that the next step is +1.
- R10: The same behaviour holds for MOD = 7 and for other sample widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Correction mode: 00 bit-0 inversion, 01 alternating ±1, 10/11 constant +1 |
| din | input | W | Signed input sample |
| dout | output | W | Signed sample forwarded to all filter branches |
| dmod | output | 1 | High when `dout` was altered |

## Verification
The assertions check four things on every cycle: that no output has zero residue, that pass-through and the modify flag agree with the sample taken the cycle before, that bit-0 inversion touches nothing else, and that constant mode adds exactly one away from the range limit. Some behaviour depends on history or on corner values, and only the bench scenarios show it. This covers the alternating sign sequence and its reset phase, the state being held across other modes and unmodified samples, and the range override. For the override, the bench uses 4-bit instances where 7 and −8 are multiples of the modulus. The sweeps run every input value in every mode for both m = 3 and m = 7.

// File: rtl/zres_precond.sv
module zres_precond #(
  parameter int W   = 8,
  parameter int MOD = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dmod
);
  localparam logic [1:0]   MODE_LSB = 2'b00;
  localparam logic [1:0]   MODE_ALT = 2'b01;
  localparam logic [W-1:0] SMAX     = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN     = {1'b1, {(W-1){1'b0}}};

  logic              alt_neg;
  logic signed [31:0] x_wide;
  logic              zero_res;
  logic              want_up, use_up;
  logic [W-1:0]      flipped, stepped, nxt;

  assign x_wide   = 32'($signed(din));
  assign zero_res = (x_wide % MOD) == 0;

  assign want_up  = (mode == MODE_ALT) ? !alt_neg : 1'b1;
  assign use_up   = want_up ? (din != SMAX) : (din == SMIN);
  assign stepped  = use_up ? din + 1'b1 : din - 1'b1;
  assign flipped  = {din[W-1:1], ~din[0]};

  assign nxt = !zero_res          ? din     :
               (mode == MODE_LSB) ? flipped : stepped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dmod    <= 1'b0;
      alt_neg <= 1'b0;
    end else begin
      dout <= nxt;
      dmod <= zero_res;
      if (zero_res && mode == MODE_ALT) alt_neg <= !alt_neg;
    end
  end
endmodule

module zres_precond_chk #(
  parameter int W   = 8,
  parameter int MOD = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic [W-1:0] din,
  input logic [W-1:0] dout,
  input logic         dmod
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};

  logic         seen;
  logic [W-1:0] prev_din;
  logic [1:0]   prev_mode;
  logic         prev_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      prev_din  <= '0;
      prev_mode <= '0;
      prev_zero <= 1'b0;
    end else begin
      seen      <= 1'b1;
      prev_din  <= din;
      prev_mode <= mode;
      prev_zero <= ((32'($signed(din))) % MOD) == 0;
    end
  end

  assert_no_zero_residue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((32'($signed(dout)) % MOD) != 0));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !prev_zero) |-> (dout == prev_din && !dmod));

  assert_flag_tracks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (dmod == prev_zero));

  assert_lsb_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && dmod && prev_mode == 2'b00) |-> ((dout ^ prev_din) == {{(W-1){1'b0}}, 1'b1}));

  assert_plus_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && dmod && prev_mode[1] && prev_din != SMAX) |-> (dout == prev_din + 1'b1));
endmodule

bind zres_precond zres_precond_chk #(.W(W), .MOD(MOD)) chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .din(din), .dout(dout), .dmod(dmod)
);

// File: tb/zres_precond_test.sv
module zres_precond_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] d8 = '0;
  logic [3:0] d4 = '0;
  logic [7:0] q3, q7;
  logic [3:0] qn, qm;
  logic       f3, f7, fn, fm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int alt [4];

  always #2.5 clk = ~clk;

  zres_precond #(.W(8), .MOD(3)) uut  (.clk(clk), .rst_n(rst_n), .mode(mode), .din(d8), .dout(q3), .dmod(f3));
  zres_precond #(.W(8), .MOD(7)) uut7 (.clk(clk), .rst_n(rst_n), .mode(mode), .din(d8), .dout(q7), .dmod(f7));
  zres_precond #(.W(4), .MOD(7)) uutn (.clk(clk), .rst_n(rst_n), .mode(mode), .din(d4), .dout(qn), .dmod(fn));
  zres_precond #(.W(4), .MOD(2)) uutm (.clk(clk), .rst_n(rst_n), .mode(mode), .din(d4), .dout(qm), .dmod(fm));

  function automatic int model(input int x, input int md, input int w, input int m,
                               inout int a, output bit f, output string tag);
    int maxv = (1 << (w - 1)) - 1;
    int minv = -(1 << (w - 1));
    int d;
    f = (x % m) == 0;
    if (!f) begin tag = "R2"; return x; end
    if (md == 0) begin tag = "R3"; return x ^ 1; end
    if (md == 1) begin
      d = a ? -1 : 1;
      a = a ^ 1;
      tag = "R4/R5";
    end else begin
      d = 1;
      tag = "R6";
    end
    if (x + d > maxv) begin d = -1; tag = "R7"; end
    if (x + d < minv) begin d = 1;  tag = "R7"; end
    return x + d;
  endfunction

  task automatic check(input string tag, input string who, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, who, got, exp);
    end
  endtask

  task automatic apply(input int v, input int md);
    int e [4];
    bit ef [4];
    string tg [4];
    d8 = v[7:0];
    d4 = v[3:0];
    mode = md[1:0];
    e[0] = model(int'($signed(d8)), md, 8, 3, alt[0], ef[0], tg[0]);
    e[1] = model(int'($signed(d8)), md, 8, 7, alt[1], ef[1], tg[1]);
    e[2] = model(int'($signed(d4)), md, 4, 7, alt[2], ef[2], tg[2]);
    e[3] = model(int'($signed(d4)), md, 4, 2, alt[3], ef[3], tg[3]);
    @(posedge clk);
    @(negedge clk);
    check(tg[0], "m3 dout", int'($signed(q3)), e[0]);
    check({tg[1], " R10"}, "m7 dout", int'($signed(q7)), e[1]);
    check(tg[2], "w4m7 dout", int'($signed(qn)), e[2]);
    check(tg[3], "w4m2 dout", int'($signed(qm)), e[3]);
    check("R8", "m3 flag", int'(f3), int'(ef[0]));
    check("R8 R10", "m7 flag", int'(f7), int'(ef[1]));
    check("R8", "w4 flags", int'({fn, fm}), int'({ef[2], ef[3]}));
    check("R1", "m3 residue", int'((int'($signed(q3)) % 3) != 0), 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    foreach (alt[i]) alt[i] = 0;
    @(negedge clk);
    check("R9", "reset dout", int'({q3, q7, qn, qm}), 0);
    check("R9", "reset flag", int'({f3, f7, fn, fm}), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    d8 = '0;
    @(negedge clk);
    do_reset();
    for (int md = 0; md < 4; md++)
      for (int v = 0; v < 256; v++) apply(v, md);

    // R5: alternation held across unmodified samples and other modes
    do_reset();
    apply(3, 1);
    apply(1, 1);
    apply(0, 0);
    apply(9, 2);
    apply(6, 1);
    apply(-3, 1);

    // R7: 4-bit corner values (7 for m=7, -8 for m=2)
    do_reset();
    apply(7, 2);
    apply(-8, 1);
    apply(-8, 1);
    apply(7, 1);
    apply(7, 1);

    // R9: mid-run reset restores +1 phase
    do_reset();
    apply(6, 1);
    apply(-6, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule